// File: doc/BRIEF.md
# Machine-Cycle Clock Divider with Automatic Switchback

This block derives a machine-cycle enable from the oscillator clock at a ratio chosen by software through a two-bit divide-select field. Three fast settings run one, two or four machine cycles per oscillator clock. The slowest setting, a low-power mode, issues one machine cycle for every 1024 oscillator clocks. A machine-cycle enable pulse and a per-clock machine-cycle count go to the rest of the processor. The count carries the fast ratios, because an enable can fire at most once per clock.

A switchback enable bit lets the hardware take the processor out of the low-power setting on its own. When that bit is set and the divider is in the slowest setting, several events force the divide-select field to the one-to-one code: a qualified external interrupt pin at its active level, a falling edge on an enabled serial receive pin, or any serial transmit activity. Software can read the field back to see whether a write took effect. A write that asks for the slowest setting while a serial port is busy is refused, and the field is left at one-to-one.

Top module: `mcd_top`

## Requirements
- R1: During and after reset, the divide-select output reads 10b, the switchback enable reads 0, the machine-cycle enable is high on every clock, and the machine-cycle count is 1.
- R2: Divide-select 00b gives a machine-cycle count of 4, 01b gives 2, and 10b gives 1. In all three settings the machine-cycle enable is high on every clock.
- R3: Divide-select 11b pulses the machine-cycle enable once every 1024 clocks. The first pulse comes 1023 clocks after the clock edge that loads 11b. The count equals the enable (1 or 0).
- R4: With switchback enabled and divide-select 11b, an external interrupt pin that is enabled, priority-allowed and at its active level sets the field to 10b at the next clock edge. Pins 0, 1, 3 and 5 are active low. Pins 2 and 4 are active high. The enable is high from that cycle on.
- R5: Under the same conditions, a high-to-low transition on serial receive pin k while receive-enable k is 1 forces 10b. A falling edge with receive disabled does not. A pin that is merely held low does not.
- R6: Under the same conditions, any transmit-busy bit at 1 forces 10b.
- R7: An interrupt pin that is not enabled, not priority-allowed, or at its inactive level does not change the field.
- R8: While the switchback enable is 0, no interrupt or serial activity changes the field from 11b.
- R9: In settings 00b and 01b, interrupt and serial activity leave the field unchanged.
- R10: A write of 11b while any transmit-busy or receive-busy bit is 1 loads 10b instead.
- R11: Every other write loads both fields as written, and the outputs show their current values.
- R12: When a switchback and a write fall on the same clock edge, the divide-select field takes 10b, and the switchback enable still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrDivSel | input | 2 | Divide-select value to write |
| wrSwbEn | input | 1 | Switchback enable value to write |
| intPin | input | 6 | External interrupt pin levels |
| intEn | input | 6 | Per-pin interrupt enable |
| intAllowed | input | 6 | Per-pin allowed by nesting priority |
| rxPin | input | 2 | Serial receive pin levels |
| rxEn | input | 2 | Per-port receive enable |
| txBusy | input | 2 | Per-port transmit in progress |
| rxBusy | input | 2 | Per-port receive in progress |
| divSel | output | 2 | Current divide-select field |
| swbEn | output | 1 | Current switchback enable |
| mcEn | output | 1 | Machine-cycle enable |
| mcCount | output | 3 | Machine cycles in this clock |

## Verification
Inputs change just after a falling edge, and outputs are sampled at a falling edge. A write, a switchback or a refused write therefore shows on the divide-select output at the first falling edge after the rising edge that sampled it, which is one clock after the stimulus. The bench checks it there. For events that must have no effect, the field is sampled over three clocks. Slow-mode pulse timing is measured by counting falling edges after the loading edge: the first pulse is due at sample 1023 and the second at sample 2047. The enable and count respond to the field in the same cycle.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [1:0] {
    DIV_QUAD   = 2'b00,
    DIV_DOUBLE = 2'b01,
    DIV_ONE    = 2'b10,
    DIV_SLOW   = 2'b11
  } divSel_e;

  localparam int MULT_W = 3;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic              slowRun;
    logic              cntClear;
    logic [MULT_W-1:0] fastMult;
  } dpStrobe_t;

endpackage

// File: rtl/mcd_ctrl.sv
module mcd_ctrl
  import mcd_pkg::*;
#(
  parameter int                 NUM_INT      = 6,
  parameter int                 NUM_SER      = 2,
  parameter logic [NUM_INT-1:0] INT_ACT_HIGH = 6'b010100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrDivSel,
  input  logic               wrSwbEn,
  input  logic [NUM_INT-1:0] intPin,
  input  logic [NUM_INT-1:0] intEn,
  input  logic [NUM_INT-1:0] intAllowed,
  input  logic [NUM_SER-1:0] rxPin,
  input  logic [NUM_SER-1:0] rxEn,
  input  logic [NUM_SER-1:0] txBusy,
  input  logic [NUM_SER-1:0] rxBusy,
  output divSel_e            divSel,
  output logic               swbEn,
  output dpStrobe_t          strobe
);

  logic [NUM_INT-1:0] intActive;
  logic [NUM_SER-1:0] rxPrev;
  logic [NUM_SER-1:0] rxFall;
  logic               intHit;
  logic               serBusy;
  logic               trigger;
  logic               slowNow;
  logic               swBack;
  divSel_e            divReg;
  divSel_e            divNext;
  logic               swbReg;
  logic               swbNext;

  // Active level per pin is chosen by parameter
  generate
    for (genvar g = 0; g < NUM_INT; g++) begin : g_intLevel
      if (INT_ACT_HIGH[g]) begin : g_high
        assign intActive[g] = intPin[g];
      end else begin : g_low
        assign intActive[g] = ~intPin[g];
      end
    end
  endgenerate

  // Falling-edge detect on each receive pin, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= '1;
    else       rxPrev <= rxPin;
  end

  assign rxFall  = rxPrev & ~rxPin & rxEn;
  assign intHit  = |(intActive & intEn & intAllowed);
  assign serBusy = (|txBusy) | (|rxBusy);
  assign trigger = intHit | (|rxFall) | (|txBusy);
  assign slowNow = (divReg == DIV_SLOW);
  assign swBack  = slowNow & swbReg & trigger;

  always_comb begin
    divNext = divReg;
    if (swBack) begin
      divNext = DIV_ONE;
    end else if (wrEn) begin
      if ((divSel_e'(wrDivSel) == DIV_SLOW) && serBusy) divNext = DIV_ONE;
      else                                              divNext = divSel_e'(wrDivSel);
    end
  end

  assign swbNext = wrEn ? wrSwbEn : swbReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_ONE;
      swbReg <= 1'b0;
    end else begin
      divReg <= divNext;
      swbReg <= swbNext;
    end
  end

  always_comb begin
    strobe.slowRun  = slowNow;
    strobe.cntClear = swBack | (divNext != divReg);
    unique case (divReg)
      DIV_QUAD:   strobe.fastMult = MULT_W'(4);
      DIV_DOUBLE: strobe.fastMult = MULT_W'(2);
      DIV_ONE:    strobe.fastMult = MULT_W'(1);
      default:    strobe.fastMult = MULT_W'(0);
    endcase
  end

  assign divSel = divReg;
  assign swbEn  = swbReg;

endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
  import mcd_pkg::*;
#(
  parameter int SLOW_RATIO = 1024,
  localparam int CNT_W     = $clog2(SLOW_RATIO)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic              mcEn,
  output logic [MULT_W-1:0] mcCount
);

  logic [CNT_W-1:0] slowCnt;
  logic             slowPulse;

  assign slowPulse = (slowCnt == CNT_W'(SLOW_RATIO - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              slowCnt <= '0;
    else if (!strobe.slowRun || strobe.cntClear) slowCnt <= '0;
    else if (slowPulse)                     slowCnt <= '0;
    else                                    slowCnt <= slowCnt + 1'b1;
  end

  assign mcEn    = strobe.slowRun ? slowPulse : 1'b1;
  assign mcCount = strobe.slowRun ? {{(MULT_W-1){1'b0}}, slowPulse} : strobe.fastMult;

endmodule

// File: rtl/mcd_top.sv
module mcd_top
  import mcd_pkg::*;
#(
  parameter int                 NUM_INT      = 6,
  parameter int                 NUM_SER      = 2,
  parameter logic [NUM_INT-1:0] INT_ACT_HIGH = 6'b010100,
  parameter int                 SLOW_RATIO   = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrDivSel,
  input  logic               wrSwbEn,
  input  logic [NUM_INT-1:0] intPin,
  input  logic [NUM_INT-1:0] intEn,
  input  logic [NUM_INT-1:0] intAllowed,
  input  logic [NUM_SER-1:0] rxPin,
  input  logic [NUM_SER-1:0] rxEn,
  input  logic [NUM_SER-1:0] txBusy,
  input  logic [NUM_SER-1:0] rxBusy,
  output logic [1:0]         divSel,
  output logic               swbEn,
  output logic               mcEn,
  output logic [2:0]         mcCount
);

  dpStrobe_t strobe;
  divSel_e   divSelInt;

  mcd_ctrl #(
    .NUM_INT     (NUM_INT),
    .NUM_SER     (NUM_SER),
    .INT_ACT_HIGH(INT_ACT_HIGH)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrDivSel  (wrDivSel),
    .wrSwbEn   (wrSwbEn),
    .intPin    (intPin),
    .intEn     (intEn),
    .intAllowed(intAllowed),
    .rxPin     (rxPin),
    .rxEn      (rxEn),
    .txBusy    (txBusy),
    .rxBusy    (rxBusy),
    .divSel    (divSelInt),
    .swbEn     (swbEn),
    .strobe    (strobe)
  );

  mcd_datapath #(
    .SLOW_RATIO(SLOW_RATIO)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .mcEn   (mcEn),
    .mcCount(mcCount)
  );

  assign divSel = divSelInt;

endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrDivSel,
  input logic [5:0] intPin,
  input logic [5:0] intEn,
  input logic [5:0] intAllowed,
  input logic [1:0] txBusy,
  input logic [1:0] rxBusy,
  input logic [1:0] divSel,
  input logic       swbEn,
  input logic       mcEn,
  input logic [2:0] mcCount
);

  logic [5:0] qualInt;
  assign qualInt = (intPin ~^ 6'b010100) & intEn & intAllowed;

  // R4 / R6: qualified interrupt or transmit activity forces one-to-one
  p_switchback_r4: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b11 && swbEn && ((|qualInt) || (|txBusy))) |=> divSel == 2'b10);

  // R8: with switchback off and no write the slow field is held
  p_swb_off_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b11 && !swbEn && !wrEn) |=> divSel == 2'b11);

  // R10: slow-mode write is refused while serial is busy
  p_busy_reject_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrDivSel == 2'b11 && ((|txBusy) || (|rxBusy))) |=> divSel == 2'b10);

  // R3: in slow mode the count mirrors the enable
  p_slow_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b11) |-> (mcCount == {2'b00, mcEn}));

  // R3: no two adjacent pulses while staying in slow mode
  p_slow_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (divSel == 2'b11 && mcEn && !wrEn) |=> !mcEn);

  // R2: fast settings run every clock with the matching count
  p_fast_rate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (divSel != 2'b11) |-> (mcEn && mcCount == (divSel == 2'b00 ? 3'd4 : (divSel == 2'b01 ? 3'd2 : 3'd1))));

  // R9: fast settings change only on a write
  p_fast_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (divSel != 2'b11 && !wrEn) |=> $stable(divSel));

endmodule

bind mcd_top mcd_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrDivSel  (wrDivSel),
  .intPin    (intPin),
  .intEn     (intEn),
  .intAllowed(intAllowed),
  .txBusy    (txBusy),
  .rxBusy    (rxBusy),
  .divSel    (divSel),
  .swbEn     (swbEn),
  .mcEn      (mcEn),
  .mcCount   (mcCount)
);

// File: tb/mcd_top_tb.sv
module mcd_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] INT_IDLE = 6'b101011;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrDivSel = 2'b10;
  logic       wrSwbEn = 1'b0;
  logic [5:0] intPin = INT_IDLE;
  logic [5:0] intEn = '0;
  logic [5:0] intAllowed = '0;
  logic [1:0] rxPin = 2'b11;
  logic [1:0] rxEn = '0;
  logic [1:0] txBusy = '0;
  logic [1:0] rxBusy = '0;
  logic [1:0] divSel;
  logic       swbEn;
  logic       mcEn;
  logic [2:0] mcCount;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcd_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDivSel(wrDivSel), .wrSwbEn(wrSwbEn),
    .intPin(intPin), .intEn(intEn), .intAllowed(intAllowed),
    .rxPin(rxPin), .rxEn(rxEn), .txBusy(txBusy), .rxBusy(rxBusy),
    .divSel(divSel), .swbEn(swbEn), .mcEn(mcEn), .mcCount(mcCount)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    intPin = INT_IDLE; intEn = '0; intAllowed = '0;
    rxPin = 2'b11; rxEn = '0; txBusy = '0; rxBusy = '0;
  endtask

  // Drive a write just after a falling edge; result visible at the next one
  task automatic writeReg(logic [1:0] sel, logic swb);
    wrEn = 1'b1; wrDivSel = sel; wrSwbEn = swb;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic holdCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*2);
    chk("R1 divSel in reset", divSel, 2);
    chk("R1 swbEn in reset", swbEn, 0);
    @(negedge clk); rstN = 1'b1;
    holdCycles(2);
    chk("R1 divSel after reset", divSel, 2);
    chk("R1 mcEn after reset", mcEn, 1);
    chk("R1 mcCount after reset", mcCount, 1);
  endtask

  task automatic t_fastModes();
    writeReg(2'b00, 1'b0);
    chk("R11 readback 00", divSel, 0);
    chk("R2 count 00", mcCount, 4);
    chk("R2 enable 00", mcEn, 1);
    writeReg(2'b01, 1'b1);
    chk("R11 readback 01", divSel, 1);
    chk("R11 swbEn readback", swbEn, 1);
    chk("R2 count 01", mcCount, 2);
    writeReg(2'b10, 1'b0);
    chk("R2 count 10", mcCount, 1);
    chk("R2 enable 10", mcEn, 1);
  endtask

  task automatic t_slowTiming();
    int first = -1;
    int second = -1;
    int zeroCnt = -1;
    writeReg(2'b11, 1'b0);
    for (int k = 0; k < 2100; k++) begin
      if (k == 5) zeroCnt = mcCount;
      if (mcEn) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
      @(negedge clk);
    end
    chk("R3 first slow pulse index", first, 1023);
    chk("R3 second slow pulse index", second, 2047);
    chk("R3 count between pulses", zeroCnt, 0);
    writeReg(2'b10, 1'b0);
  endtask

  task automatic t_intSwitchback();
    for (int i = 0; i < 6; i++) begin
      writeReg(2'b11, 1'b1);
      intPin = INT_IDLE ^ (6'b1 << i);
      intEn = 6'b1 << i;
      intAllowed = 6'b1 << i;
      @(negedge clk);
      chk($sformatf("R4 switchback pin %0d", i), divSel, 2);
      chk($sformatf("R4 enable after pin %0d", i), mcEn, 1);
      idleInputs();
    end
  endtask

  task automatic t_intQualifiers();
    writeReg(2'b11, 1'b1);
    intPin = INT_IDLE ^ 6'b000001; intEn = 6'b000001; intAllowed = 6'b000000;
    holdCycles(3);
    chk("R7 not allowed", divSel, 3);
    intEn = 6'b000000; intAllowed = 6'b000001;
    holdCycles(3);
    chk("R7 not enabled", divSel, 3);
    intPin = INT_IDLE; intEn = 6'b111111; intAllowed = 6'b111111;
    holdCycles(3);
    chk("R7 inactive levels", divSel, 3);
    idleInputs();
    writeReg(2'b10, 1'b0);
  endtask

  task automatic t_swbOff();
    writeReg(2'b11, 1'b0);
    intPin = INT_IDLE ^ 6'b000100; intEn = 6'b000100; intAllowed = 6'b000100;
    txBusy = 2'b01;
    rxEn = 2'b11; rxPin = 2'b00;
    holdCycles(3);
    chk("R8 no switchback when disabled", divSel, 3);
    idleInputs();
    holdCycles(1);
    writeReg(2'b10, 1'b0);
  endtask

  task automatic t_serial();
    writeReg(2'b11, 1'b1);
    rxPin = 2'b01;
    holdCycles(3);
    chk("R5 fall without receive enable", divSel, 3);
    rxEn = 2'b10;
    holdCycles(3);
    chk("R5 pin held low, no edge", divSel, 3);
    rxPin = 2'b11;
    @(negedge clk);
    chk("R5 rising edge ignored", divSel, 3);
    rxPin = 2'b01;
    @(negedge clk);
    chk("R5 enabled falling edge", divSel, 2);
    idleInputs();
    holdCycles(1);
    writeReg(2'b11, 1'b1);
    txBusy = 2'b10;
    @(negedge clk);
    chk("R6 transmit activity", divSel, 2);
    idleInputs();
  endtask

  task automatic t_otherModes();
    writeReg(2'b00, 1'b1);
    intPin = INT_IDLE ^ 6'b001000; intEn = 6'b001000; intAllowed = 6'b001000;
    txBusy = 2'b11; rxEn = 2'b11; rxPin = 2'b00;
    holdCycles(3);
    chk("R9 setting 00 unaffected", divSel, 0);
    idleInputs();
    writeReg(2'b01, 1'b1);
    txBusy = 2'b01;
    holdCycles(3);
    chk("R9 setting 01 unaffected", divSel, 1);
    chk("R9 count stays 2", mcCount, 2);
    idleInputs();
  endtask

  task automatic t_blockWrite();
    txBusy = 2'b10;
    writeReg(2'b11, 1'b1);
    chk("R10 refused during transmit", divSel, 2);
    txBusy = 2'b00;
    writeReg(2'b00, 1'b0);
    rxBusy = 2'b01;
    writeReg(2'b11, 1'b0);
    chk("R10 refused during receive", divSel, 2);
    rxBusy = 2'b00;
    writeReg(2'b11, 1'b0);
    chk("R11 accepted when idle", divSel, 3);
    writeReg(2'b10, 1'b0);
  endtask

  task automatic t_priority();
    writeReg(2'b11, 1'b1);
    intPin = INT_IDLE ^ 6'b010000; intEn = 6'b010000; intAllowed = 6'b010000;
    wrEn = 1'b1; wrDivSel = 2'b11; wrSwbEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R12 switchback beats write", divSel, 2);
    chk("R12 swbEn from write", swbEn, 0);
    idleInputs();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    t_reset();
    t_fastModes();
    t_slowTiming();
    t_intSwitchback();
    t_intQualifiers();
    t_swbOff();
    t_serial();
    t_otherModes();
    t_blockWrite();
    t_priority();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule